// File: doc/BRIEF.md
# Mobile DRAM Initialization Sequencer

This block is the controller-side state machine that finishes bringing one or more low-power DDR2 devices out of power-up. A one-cycle start pulse, given at the moment the reset command has gone out, launches the sequence. The block then walks through three phases. First it polls each device's auto-initialization status with mode-register reads. Next it issues one impedance-calibration mode-register write per device, serialized. Last it writes the three configuration mode registers. After that it raises a ready flag, and normal traffic may begin.

The status phase for a device ends on whichever comes first: the device reports that its auto-initialization is finished, or the maximum initialization window (counted from start) runs out. When the window runs out while a device still reports busy, a sticky timeout flag is raised. The sequence then carries on, because the window bounds how long any device may stay busy. All intervals are parameters counted in controller clocks. The command interface is abstract: a command code, a per-device chip-select vector, a mode-register address, write data, and read data returned with a valid strobe.

Top module: `lpddr_init_seq`

## Requirements
- R1: While rst_ni is low, and afterwards until start_i is sampled high in the idle state, cmd_o is NOP and cs_o, ready_o and timeout_o are all 0. A start_i pulse given at any other time has no effect on the command stream or the flags.
- R2: Command codes on cmd_o are NOP=0, MRR=1 and MRW=2. The first command after start is an MRR with ma_o=0 to device 0, issued in the cycle after start_i is sampled. Devices are polled in ascending index order, and during polling only MRR commands with ma_o=0 appear.
- R3: Two MRR commands are never closer than T_POLL cycles. A new MRR is issued only after rvalid_i has returned the result of the previous one.
- R4: The auto-initialization status is bit 0 of rdata_i when rvalid_i is high. A 1 makes the block poll the same device again. A 0 moves polling to the next device, or after the last device ends polling without waiting for the window to run out.
- R5: If T_INIT5 cycles have elapsed since start and the device being polled has not reported 0, timeout_o goes high and stays high until reset. Polling stops and the calibration phase follows. The first calibration write then comes no earlier than T_INIT5 cycles after start.
- R6: Calibration writes are MRW with ma_o=10 and wdata_o=ZQ_INIT_CODE (default 0xFF). Each one selects exactly one device, devices are taken in ascending order, and each device is calibrated once per run. Consecutive calibration writes are exactly T_ZQINIT cycles apart, and the first configuration write comes exactly T_ZQINIT cycles after the last calibration write.
- R7: Configuration writes are MRW to ma_o=1, 2 and 3 in that order, carrying mr1_cfg_i, mr2_cfg_i and mr3_cfg_i respectively, with every cs_o bit set. Consecutive configuration writes are exactly T_MRW cycles apart.
- R8: ready_o rises exactly T_MRW cycles after the ma_o=3 write and stays high until reset. No command is issued while ready_o is high.
- R9: cs_o is all zero whenever cmd_o is NOP, and one-hot for every MRR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse, sampled only in the idle state |
| cmd_o | output | 2 | Command code: 0 NOP, 1 MRR, 2 MRW |
| cs_o | output | NUM_DEV | Per-device chip select |
| ma_o | output | MA_W | Mode-register address |
| wdata_o | output | DQ_W | Mode-register write data |
| rdata_i | input | DQ_W | Mode-register read data |
| rvalid_i | input | 1 | Read data valid strobe |
| mr1_cfg_i | input | DQ_W | Value for configuration register 1 |
| mr2_cfg_i | input | DQ_W | Value for configuration register 2 |
| mr3_cfg_i | input | DQ_W | Value for configuration register 3 |
| ready_o | output | 1 | Sequence complete, device open for normal traffic |
| timeout_o | output | 1 | Window expired while a device still reported busy |

## Verification
The properties assume that rvalid_i pulses for exactly one cycle in answer to each MRR, and only while that read is outstanding. They also assume that rdata_i is meaningful only in that cycle and that start_i is a single-cycle pulse. The bench's device model keeps to this. It watches cmd_o, answers every MRR once after a fixed latency with a busy count chosen per device, and never raises rvalid_i without a pending read. Extra start pulses are placed mid-run and after completion, where the requirements say they must be ignored.

// File: rtl/lpis_pkg.sv
package lpis_pkg;

   typedef enum logic [1:0] {
      CMD_NOP = 2'd0,
      CMD_MRR = 2'd1,
      CMD_MRW = 2'd2
   } lpis_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_POLL,
      ST_POLL_WAIT,
      ST_ZQ,
      ST_CFG,
      ST_DONE
   } lpis_state_e;

   // mode-register addresses the sequence relies on
   localparam int MR_STATUS = 0;
   localparam int MR_ZQ     = 10;
   // bit of the status register that reads 1 while auto-init runs
   localparam int BUSY_BIT  = 0;

endpackage

// File: rtl/lpis_down_timer.sv
module lpis_down_timer #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - W'(1);
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lpis_zq_slot.sv
module lpis_zq_slot (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clear_i,
   input  logic issue_i,
   output logic done_o
);

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         done_o <= 1'b0;
      else if (clear_i)
         done_o <= 1'b0;
      else if (issue_i)
         done_o <= 1'b1;
   end

endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
   import lpis_pkg::*;
#(
   parameter int         NUM_DEV      = 2,
   parameter int         MA_W         = 8,
   parameter int         DQ_W         = 8,
   parameter int         T_INIT5      = 10000,
   parameter int         T_ZQINIT     = 1000,
   parameter int         T_MRW        = 5,
   parameter int         T_POLL       = 16,
   parameter logic [7:0] ZQ_INIT_CODE = 8'hFF
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   output logic [1:0]         cmd_o,
   output logic [NUM_DEV-1:0] cs_o,
   output logic [MA_W-1:0]    ma_o,
   output logic [DQ_W-1:0]    wdata_o,
   input  logic [DQ_W-1:0]    rdata_i,
   input  logic               rvalid_i,
   input  logic [DQ_W-1:0]    mr1_cfg_i,
   input  logic [DQ_W-1:0]    mr2_cfg_i,
   input  logic [DQ_W-1:0]    mr3_cfg_i,
   output logic               ready_o,
   output logic               timeout_o
);

   localparam int GAP_A   = (T_POLL > T_MRW) ? T_POLL : T_MRW;
   localparam int GAP_MAX = (GAP_A > T_ZQINIT) ? GAP_A : T_ZQINIT;
   localparam int GAP_W   = $clog2(GAP_MAX + 1);
   localparam int T5_W    = $clog2(T_INIT5 + 1);
   localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

   // elaboration-time parameter checks
   if (NUM_DEV < 1) begin : g_bad_dev
      $error("NUM_DEV must be at least 1");
   end
   if (T_POLL < 1 || T_MRW < 1 || T_ZQINIT < 1 || T_INIT5 < 1) begin : g_bad_time
      $error("all timing windows must be at least one cycle");
   end
   if (MA_W < 4) begin : g_bad_ma
      $error("MA_W must reach address 10");
   end
   if (DQ_W < 8) begin : g_bad_dq
      $error("DQ_W must be at least 8");
   end

   lpis_state_e          state_q, state_d;
   logic [DEV_W-1:0]     dev_q, dev_d;
   logic [1:0]           idx_q, idx_d;
   logic                 timeout_q, timeout_d;

   logic                 gap_load, gap_zero;
   logic [GAP_W-1:0]     gap_val;
   logic                 t5_load, t5_zero;

   logic [NUM_DEV-1:0]   zq_done;
   logic [NUM_DEV-1:0]   zq_one;
   logic [NUM_DEV-1:0]   zq_issue;
   logic                 zq_clear;
   logic [NUM_DEV-1:0]   poll_one;
   logic                 busy_bit;

   // spacing timer shared by every phase
   lpis_down_timer #(.W(GAP_W)) u_gap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (gap_load),
      .val_i  (gap_val),
      .zero_o (gap_zero)
   );

   // auto-initialization window, started by the launch pulse
   lpis_down_timer #(.W(T5_W)) u_init5 (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (t5_load),
      .val_i  (T5_W'(T_INIT5)),
      .zero_o (t5_zero)
   );

   // one calibration record per device
   for (genvar d = 0; d < NUM_DEV; d++) begin : g_zq
      lpis_zq_slot u_slot (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .clear_i (zq_clear),
         .issue_i (zq_issue[d]),
         .done_o  (zq_done[d])
      );
   end

   // next device to calibrate: lowest index not yet done
   if (NUM_DEV == 1) begin : g_sel_single
      assign zq_one = 1'b1;
   end else begin : g_sel_multi
      always_comb begin
         zq_one = '0;
         for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (!zq_done[i])
               zq_one = NUM_DEV'(1) << i;
         end
      end
   end

   assign poll_one = NUM_DEV'(1) << dev_q;
   assign busy_bit = rdata_i[BUSY_BIT];

   always_comb begin
      state_d   = state_q;
      dev_d     = dev_q;
      idx_d     = idx_q;
      timeout_d = timeout_q;
      cmd_o     = CMD_NOP;
      cs_o      = '0;
      ma_o      = '0;
      wdata_o   = '0;
      gap_load  = 1'b0;
      gap_val   = '0;
      t5_load   = 1'b0;
      zq_issue  = '0;
      zq_clear  = 1'b0;

      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d  = ST_POLL;
               dev_d    = '0;
               t5_load  = 1'b1;
               zq_clear = 1'b1;
            end
         end

         ST_POLL: begin
            if (gap_zero) begin
               cmd_o    = CMD_MRR;
               cs_o     = poll_one;
               ma_o     = MA_W'(MR_STATUS);
               gap_load = 1'b1;
               gap_val  = GAP_W'(T_POLL - 1);
               state_d  = ST_POLL_WAIT;
            end
         end

         ST_POLL_WAIT: begin
            if (rvalid_i && !busy_bit) begin
               if (dev_q == DEV_W'(NUM_DEV - 1)) begin
                  state_d = ST_ZQ;
               end else begin
                  dev_d   = dev_q + DEV_W'(1);
                  state_d = ST_POLL;
               end
            end else if (t5_zero) begin
               timeout_d = 1'b1;
               state_d   = ST_ZQ;
            end else if (rvalid_i) begin
               state_d = ST_POLL;
            end
         end

         ST_ZQ: begin
            if (gap_zero) begin
               cmd_o    = CMD_MRW;
               cs_o     = zq_one;
               ma_o     = MA_W'(MR_ZQ);
               wdata_o  = DQ_W'(ZQ_INIT_CODE);
               zq_issue = zq_one;
               gap_load = 1'b1;
               gap_val  = GAP_W'(T_ZQINIT - 1);
               if (&(zq_done | zq_one)) begin
                  state_d = ST_CFG;
                  idx_d   = 2'd0;
               end
            end
         end

         ST_CFG: begin
            if (gap_zero) begin
               cmd_o    = CMD_MRW;
               cs_o     = '1;
               ma_o     = MA_W'(idx_q) + MA_W'(1);
               case (idx_q)
                  2'd0:    wdata_o = mr1_cfg_i;
                  2'd1:    wdata_o = mr2_cfg_i;
                  default: wdata_o = mr3_cfg_i;
               endcase
               gap_load = 1'b1;
               gap_val  = GAP_W'(T_MRW - 1);
               if (idx_q == 2'd2)
                  state_d = ST_DONE;
               else
                  idx_d = idx_q + 2'd1;
            end
         end

         default: begin
            // ST_DONE: terminal until reset
         end
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         dev_q     <= '0;
         idx_q     <= '0;
         timeout_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         dev_q     <= dev_d;
         idx_q     <= idx_d;
         timeout_q <= timeout_d;
      end
   end

   assign ready_o   = (state_q == ST_DONE) && gap_zero;
   assign timeout_o = timeout_q;

endmodule

// File: rtl/lpis_checker.sv
module lpis_checker
   import lpis_pkg::*;
#(
   parameter int NUM_DEV = 2,
   parameter int MA_W    = 8,
   parameter int T_POLL  = 16
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [1:0]         cmd_i,
   input logic [NUM_DEV-1:0] cs_i,
   input logic [MA_W-1:0]    ma_i,
   input logic               ready_i,
   input logic               timeout_i,
   input logic [NUM_DEV-1:0] zq_done_i
);

   localparam int CW = $clog2(T_POLL + 1) + 1;

   // cycles since the last MRR, saturating at T_POLL
   logic [CW-1:0] since_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         since_q <= CW'(T_POLL);
      else if (cmd_i == CMD_MRR)
         since_q <= '0;
      else if (since_q < CW'(T_POLL))
         since_q <= since_q + CW'(1);
   end

   p_nop_no_cs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i == CMD_NOP |-> cs_i == '0);

   p_mrr_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i == CMD_MRR |-> $countones(cs_i) == 1);

   p_mrr_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i == CMD_MRR |-> ma_i == MA_W'(MR_STATUS));

   p_poll_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i == CMD_MRR |-> since_q >= CW'(T_POLL - 1));

   p_zq_fresh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == CMD_MRW && ma_i == MA_W'(MR_ZQ))
         |-> ($countones(cs_i) == 1 && (cs_i & zq_done_i) == '0));

   p_cfg_broadcast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == CMD_MRW && ma_i != MA_W'(MR_ZQ)) |-> cs_i == '1);

   p_timeout_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_i |=> timeout_i);

   p_ready_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_i |=> ready_i);

   p_ready_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_i |-> cmd_i == CMD_NOP);

endmodule

bind lpddr_init_seq lpis_checker #(
   .NUM_DEV (NUM_DEV),
   .MA_W    (MA_W),
   .T_POLL  (T_POLL)
) u_lpis_checker (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .cmd_i     (cmd_o),
   .cs_i      (cs_o),
   .ma_i      (ma_o),
   .ready_i   (ready_o),
   .timeout_i (timeout_o),
   .zq_done_i (zq_done)
);

// File: tb/test_lpddr_init_seq.sv
module test_lpddr_init_seq;

   localparam int CLK_PERIOD = 10;
   localparam int N     = 2;
   localparam int T5    = 60;
   localparam int TZQ   = 20;
   localparam int TMRW  = 5;
   localparam int TPOLL = 8;
   localparam int RL    = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   cmd;
   logic [N-1:0] cs;
   logic [7:0]   ma, wd;
   logic [7:0]   rdata = 8'h00;
   logic         rvalid = 1'b0;
   logic [7:0]   mr1 = 8'h00, mr2 = 8'h00, mr3 = 8'h00;
   logic         ready, timeout;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lpddr_init_seq #(
      .NUM_DEV (N), .MA_W (8), .DQ_W (8), .T_INIT5 (T5),
      .T_ZQINIT (TZQ), .T_MRW (TMRW), .T_POLL (TPOLL), .ZQ_INIT_CODE (8'hFF)
   ) i_lpddr_init_seq (
      .clk_i (clk), .rst_ni (rst_n), .start_i (start),
      .cmd_o (cmd), .cs_o (cs), .ma_o (ma), .wdata_o (wd),
      .rdata_i (rdata), .rvalid_i (rvalid),
      .mr1_cfg_i (mr1), .mr2_cfg_i (mr2), .mr3_cfg_i (mr3),
      .ready_o (ready), .timeout_o (timeout)
   );

   typedef struct {
      logic [1:0]   cmd;
      logic [N-1:0] cs;
      logic [7:0]   ma;
      logic [7:0]   wd;
      int           gap;   // exact spacing to previous command, 0 = free
      bit           rep;   // MRR that may repeat any number of times
      string        tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_total = 0, n_fail = 0;
   int   busy[N];
   int   last_c = -1, last_mrr_c = -1, zq_first_c = -1, mr3_c = -1, start_c = 0;
   int   resp_cnt = 0, resp_dev = 0;
   bit   finished = 1'b0;

   function automatic int now_c();
      return int'($time / CLK_PERIOD);
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] c, input logic [N-1:0] s, input logic [7:0] a,
                       input logic [7:0] d, input int gap, input bit rep, input string tag);
      exp_t it;
      it.cmd = c; it.cs = s; it.ma = a; it.wd = d; it.gap = gap; it.rep = rep; it.tag = tag;
      sb_q.push_back(it);
   endtask

   // expected calibration and configuration tail of every run
   task automatic push_tail(input logic [7:0] c1, input logic [7:0] c2, input logic [7:0] c3);
      push(2'd2, 2'b01, 8'd10, 8'hFF, 0,    0, "R6");
      push(2'd2, 2'b10, 8'd10, 8'hFF, TZQ,  0, "R6");
      push(2'd2, 2'b11, 8'd1,  c1,    TZQ,  0, "R7");
      push(2'd2, 2'b11, 8'd2,  c2,    TMRW, 0, "R7");
      push(2'd2, 2'b11, 8'd3,  c3,    TMRW, 0, "R7");
   endtask

   // monitor: pops the scoreboard as commands appear
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && cmd != 2'd0) begin
            int t;
            exp_t it;
            t = now_c();
            if (cmd == 2'd1) begin
               if (last_mrr_c >= 0)
                  check(t - last_mrr_c >= TPOLL, "R3", "MRR spacing", t - last_mrr_c, TPOLL);
               last_mrr_c = t;
            end
            if (cmd == 2'd2 && ma == 8'd10 && zq_first_c < 0) zq_first_c = t;
            if (cmd == 2'd2 && ma == 8'd3) mr3_c = t;
            if (sb_q.size() > 0 && sb_q[0].rep && !(cmd == 2'd1 && cs == sb_q[0].cs && ma == 8'd0))
               void'(sb_q.pop_front());
            if (sb_q.size() == 0) begin
               check(1'b0, "R8", "unexpected command", int'(cmd), 0);
            end else begin
               it = sb_q[0];
               if (!it.rep) void'(sb_q.pop_front());
               check(cmd == it.cmd, it.tag, "cmd", int'(cmd), int'(it.cmd));
               check(cs == it.cs, it.tag, "cs", int'(cs), int'(it.cs));
               check(ma == it.ma, it.tag, "ma", int'(ma), int'(it.ma));
               if (cmd == 2'd2)
                  check(wd == it.wd, it.tag, "wdata", int'(wd), int'(it.wd));
               if (it.gap != 0)
                  check(t - last_c == it.gap, it.tag, "spacing", t - last_c, it.gap);
            end
            last_c = t;
         end
      end
   end

   // device model: answers each MRR once after RL cycles
   initial begin
      forever begin
         @(negedge clk);
         rvalid = 1'b0;
         if (!rst_n) begin
            resp_cnt = 0;
         end else begin
            if (resp_cnt > 0) begin
               resp_cnt--;
               if (resp_cnt == 0) begin
                  rvalid = 1'b1;
                  rdata  = {7'd0, busy[resp_dev] != 0};
                  if (busy[resp_dev] > 0) busy[resp_dev]--;
               end
            end
            if (cmd == 2'd1) begin
               resp_cnt = RL;
               resp_dev = cs[1] ? 1 : 0;
            end
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      sb_q.delete();
      last_c = -1; last_mrr_c = -1; zq_first_c = -1; mr3_c = -1;
      // R1: quiet outputs while in reset
      check(cmd == 2'd0 && cs == '0, "R1", "cmd/cs in reset", int'(cmd), 0);
      check(ready == 1'b0 && timeout == 1'b0, "R1", "flags in reset", int'({ready, timeout}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(cmd == 2'd0 && ready == 1'b0, "R1", "idle after reset", int'({ready, cmd}), 0);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      start_c = now_c();
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_ready(input string tag);
      int w = 0;
      while (!ready && w < 3000) begin
         @(negedge clk);
         w++;
      end
      check(ready == 1'b1, tag, "ready reached", int'(ready), 1);
      check(now_c() - mr3_c == TMRW, "R8", "ready after last write", now_c() - mr3_c, TMRW);
      check(sb_q.size() == 0, "R8", "scoreboard drained", sb_q.size(), 0);
   endtask

   initial begin
      // ---- run A: device 0 busy twice, device 1 done at once
      do_reset();
      busy[0] = 2; busy[1] = 0;
      mr1 = 8'h12; mr2 = 8'h34; mr3 = 8'h56;
      repeat (3) push(2'd1, 2'b01, 8'd0, 8'h00, 0, 0, "R4");
      push(2'd1, 2'b10, 8'd0, 8'h00, 0, 0, "R2");
      push_tail(8'h12, 8'h34, 8'h56);
      pulse_start();
      check(cmd == 2'd1 && cs == 2'b01, "R2", "first poll", int'({cs, cmd}), 5);
      repeat (10) @(negedge clk);
      pulse_start();  // R1: ignored mid-run
      wait_ready("R7");
      check(timeout == 1'b0, "R5", "no timeout on early finish", int'(timeout), 0);
      check(zq_first_c - start_c < T5 + 12, "R4", "calibration before window", zq_first_c, T5);
      pulse_start();  // R1: ignored once ready
      repeat (30) @(negedge clk);
      check(ready == 1'b1 && cmd == 2'd0, "R8", "ready holds, quiet", int'({ready, cmd}), 4);

      // ---- run B: device 0 never finishes
      do_reset();
      busy[0] = -1; busy[1] = 0;
      mr1 = 8'hA1; mr2 = 8'hB2; mr3 = 8'hC3;
      push(2'd1, 2'b01, 8'd0, 8'h00, 0, 1, "R5");
      push_tail(8'hA1, 8'hB2, 8'hC3);
      pulse_start();
      wait_ready("R5");
      check(timeout == 1'b1, "R5", "timeout flag", int'(timeout), 1);
      check(zq_first_c - (start_c + 1) >= T5, "R5", "window respected",
            zq_first_c - start_c, T5);

      // ---- run C: device 1 busy three times
      do_reset();
      check(timeout == 1'b0, "R1", "timeout cleared by reset", int'(timeout), 0);
      busy[0] = 0; busy[1] = 3;
      mr1 = 8'h0F; mr2 = 8'hF0; mr3 = 8'h5A;
      push(2'd1, 2'b01, 8'd0, 8'h00, 0, 0, "R2");
      repeat (4) push(2'd1, 2'b10, 8'd0, 8'h00, 0, 0, "R4");
      push_tail(8'h0F, 8'hF0, 8'h5A);
      pulse_start();
      wait_ready("R6");
      check(timeout == 1'b0, "R5", "no timeout run C", int'(timeout), 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "R8", "watchdog expired", 0, 1);
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

endmodule